// File: doc/BRIEF.md
# Saturating Cycle Counter Interrupt

This block counts CPU bus cycles in a 16-bit register and signals an interrupt on an active-low line once the count has climbed to all ones. The count advances by one on every clock in which the cycle-end strobe is high. At all ones it stops and stays there, so the interrupt is a level that lasts until software intervenes.

Software controls the block through three write-only slots on the CPU write bus. Only the low four address bits select the slot. Slot 0xD clears the count and disarms the interrupt, whatever the data. Slot 0xE replaces the low byte of the count. Slot 0xF replaces the high byte and arms the interrupt. A typical handler preloads the count so that it reaches all ones after a chosen number of cycles, and later writes slot 0xD to acknowledge the interrupt. Writes to the other thirteen slot numbers leave the block unchanged.

Top module: `cyc_irq_timer`

## Requirements
- R1: While `rst` is high and on the first clock after it, the count is 0x0000, the interrupt is disarmed and `irq_n` is 1.
- R2: On a clock with `cyc_end` high and no write to slots 0xD, 0xE or 0xF, a count below 0xFFFF increases by exactly one. With `cyc_end` low and no such write, the count keeps its value.
- R3: Once the count is 0xFFFF, further `cyc_end` pulses leave it at 0xFFFF. No other condition pauses counting.
- R4: `irq_n` is 0 exactly when the count is 0xFFFF and the interrupt is armed, and 1 otherwise. It is a registered output and changes on the same clock edge as the state it reflects.
- R5: A write (`wr_en` = 1) with `wr_idx` = 0xD and any `wr_data` sets the count to 0x0000 and disarms the interrupt, which releases `irq_n` to 1 on that edge.
- R6: A write with `wr_idx` = 0xE copies `wr_data` into count bits 7..0 and keeps count bits 15..8 and the arm state unchanged.
- R7: A write with `wr_idx` = 0xF copies `wr_data` into count bits 15..8, keeps count bits 7..0 and arms the interrupt.
- R8: When a write to slot 0xD, 0xE or 0xF and a `cyc_end` pulse occur on the same clock, the write takes effect and that clock's increment is dropped.
- R9: A write with `wr_idx` from 0x0 to 0xC has no effect on the count or the arm state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_end | input | 1 | High for one clock at the end of each CPU bus cycle |
| wr_en | input | 1 | CPU register write strobe |
| wr_idx | input | 4 | Slot number taken from address bits 3..0 |
| wr_data | input | 8 | Write data byte |
| irq_n | output | 1 | Active-low interrupt level |

## Verification
All results come from the clock edge that samples the stimulus. A write or tick driven after a falling edge is visible on `irq_n` after the next rising edge, so the delay is one cycle with no further lag. The driver applies each stimulus after a falling edge and queues the `irq_n` level that the requirements predict. The monitor pops that level 2 ns after the following rising edge, so every comparison lands in the single cycle in which the result is due. The inner count is reached only through `irq_n`: the bench preloads values near saturation and counts the ticks until the line drops.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;
  localparam int IDX_W = 4;

  localparam logic [IDX_W-1:0] SLOT_CLEAR   = 4'hD;
  localparam logic [IDX_W-1:0] SLOT_LOAD_LO = 4'hE;
  localparam logic [IDX_W-1:0] SLOT_LOAD_HI = 4'hF;

  typedef struct packed {
    logic clear;
    logic load_lo;
    logic load_hi;
  } wr_ctl_t;
endpackage

// File: rtl/cyc_irq_decode.sv
module cyc_irq_decode
  import cyc_irq_pkg::*;
(
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  output wr_ctl_t          ctl
);
  always_comb begin
    ctl.clear   = wr_en && (wr_idx == SLOT_CLEAR);
    ctl.load_lo = wr_en && (wr_idx == SLOT_LOAD_LO);
    ctl.load_hi = wr_en && (wr_idx == SLOT_LOAD_HI);
  end
endmodule

// File: rtl/cyc_irq_counter.sv
module cyc_irq_counter
  import cyc_irq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_end,
  input  wr_ctl_t           ctl,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              sat_d
);
  localparam int NB = CNT_W / BYTE_W;

  logic [CNT_W-1:0] inc_v;
  logic [CNT_W-1:0] cnt_d;
  logic             sat_q;
  logic             any_wr;
  logic             step;

  assign sat_q  = &cnt_q;
  assign inc_v  = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  assign any_wr = ctl.clear | ctl.load_lo | ctl.load_hi;
  assign step   = cyc_end & ~sat_q & ~any_wr;

  for (genvar l = 0; l < NB; l++) begin : g_lane
    localparam bit IS_LO = (l == 0);
    localparam bit IS_HI = (l == NB - 1);
    logic lane_ld;

    assign lane_ld = (IS_LO && ctl.load_lo) || (IS_HI && ctl.load_hi);

    always_comb begin
      if (ctl.clear)
        cnt_d[l*BYTE_W +: BYTE_W] = '0;
      else if (lane_ld)
        cnt_d[l*BYTE_W +: BYTE_W] = wr_data;
      else if (step)
        cnt_d[l*BYTE_W +: BYTE_W] = inc_v[l*BYTE_W +: BYTE_W];
      else
        cnt_d[l*BYTE_W +: BYTE_W] = cnt_q[l*BYTE_W +: BYTE_W];
    end
  end

  assign sat_d = &cnt_d;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cyc_irq_arm.sv
module cyc_irq_arm
  import cyc_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  wr_ctl_t ctl,
  input  logic    sat_d,
  output logic    arm_q,
  output logic    irq_n_q
);
  logic arm_d;

  always_comb begin
    if (ctl.clear)        arm_d = 1'b0;
    else if (ctl.load_hi) arm_d = 1'b1;
    else                  arm_d = arm_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q   <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      arm_q   <= arm_d;
      irq_n_q <= ~(arm_d & sat_d);
    end
  end
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cyc_irq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_end,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              irq_n
);
  wr_ctl_t          ctl;
  logic [CNT_W-1:0] cnt_q;
  logic             sat_d;
  logic             arm_q;

  cyc_irq_decode u_dec (
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .ctl    (ctl)
  );

  cyc_irq_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .cyc_end (cyc_end),
    .ctl     (ctl),
    .wr_data (wr_data),
    .cnt_q   (cnt_q),
    .sat_d   (sat_d)
  );

  cyc_irq_arm u_arm (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .sat_d   (sat_d),
    .arm_q   (arm_q),
    .irq_n_q (irq_n)
  );
endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk
  import cyc_irq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc_end,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [BYTE_W-1:0] wr_data,
  input logic              irq_n,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              arm_q
);
  localparam logic [CNT_W-1:0] FULL = '1;
  localparam int HI_LSB = CNT_W - BYTE_W;

  logic is_sw;
  assign is_sw = wr_en && (wr_idx >= SLOT_CLEAR);

  // R1
  reset_release_chk: assert property (@(posedge clk)
    rst |=> (irq_n && cnt_q == '0 && !arm_q));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!is_sw && cyc_end && cnt_q != FULL) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R2
  count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!is_sw && !cyc_end) |=> $stable(cnt_q));

  // R3
  saturate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!is_sw && cnt_q == FULL) |=> cnt_q == FULL);

  // R4
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_n == !(arm_q && cnt_q == FULL));

  // R5
  clear_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == SLOT_CLEAR) |=> (cnt_q == '0 && !arm_q && irq_n));

  // R6
  load_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == SLOT_LOAD_LO) |=>
      (cnt_q[BYTE_W-1:0] == $past(wr_data) &&
       cnt_q[CNT_W-1:HI_LSB] == $past(cnt_q[CNT_W-1:HI_LSB]) && $stable(arm_q)));

  // R7
  load_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == SLOT_LOAD_HI) |=>
      (cnt_q[CNT_W-1:HI_LSB] == $past(wr_data) &&
       cnt_q[BYTE_W-1:0] == $past(cnt_q[BYTE_W-1:0]) && arm_q));

  // R9
  other_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx < SLOT_CLEAR && !cyc_end) |=> ($stable(cnt_q) && $stable(arm_q)));
endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cyc_end (cyc_end),
  .wr_en   (wr_en),
  .wr_idx  (wr_idx),
  .wr_data (wr_data),
  .irq_n   (irq_n),
  .cnt_q   (cnt_q),
  .arm_q   (arm_q)
);

// File: tb/sim_cyc_irq_timer.sv
`timescale 1ns/1ps
module sim_cyc_irq_timer;
  localparam time CLK_P = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_end = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic       irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  logic [15:0] m_cnt = '0;
  bit          m_arm = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cyc_irq_timer u0 (
    .clk     (clk),
    .rst     (rst),
    .cyc_end (cyc_end),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .irq_n   (irq_n)
  );

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s irq_n actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the predicted irq_n
  task automatic step(bit we, logic [3:0] idx, logic [7:0] d, bit ce, string tag);
    @(negedge clk);
    wr_en = we; wr_idx = idx; wr_data = d; cyc_end = ce;
    if (we && idx == 4'hD) begin
      m_cnt = '0; m_arm = 1'b0;
    end else if (we && idx == 4'hE) begin
      m_cnt[7:0] = d;
    end else if (we && idx == 4'hF) begin
      m_cnt[15:8] = d; m_arm = 1'b1;
    end else if (ce && m_cnt != 16'hFFFF) begin
      m_cnt = m_cnt + 16'd1;
    end
    exp_q.push_back(!(m_arm && m_cnt == 16'hFFFF));
    tag_q.push_back(tag);
  endtask

  // monitor: compares irq_n just after the edge that registers each stimulus
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst && exp_q.size() > 0) check(irq_n, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #(CLK_P * 300000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(irq_n, 1'b1, "R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    check(irq_n, 1'b1, "R1 after reset");

    // arm via high byte, then saturate via low byte
    step(1, 4'hF, 8'hFF, 0, "R7");
    step(1, 4'hE, 8'hFF, 0, "R6");
    for (int i = 0; i < 3; i++) step(0, 4'h0, 8'h00, 0, "R4");
    for (int i = 0; i < 3; i++) step(0, 4'h0, 8'h00, 1, "R3");

    // unused slots leave a saturated, armed state alone
    for (int i = 0; i < 13; i++) step(1, 4'(i), 8'h5A, 0, "R9");

    // clear with arbitrary data
    step(1, 4'hD, 8'hA5, 0, "R5");
    step(1, 4'hE, 8'hFE, 0, "R6");
    step(1, 4'hF, 8'hFF, 0, "R7");
    step(0, 4'h0, 8'h00, 1, "R2");

    // write beats a coincident tick
    step(1, 4'hE, 8'hFD, 1, "R8");
    step(1, 4'hF, 8'hFF, 1, "R8");
    step(0, 4'h0, 8'h00, 1, "R2");
    step(0, 4'h0, 8'h00, 1, "R2");

    // low-byte load keeps high byte and arm state
    step(1, 4'hE, 8'h00, 0, "R6");
    for (int i = 0; i < 255; i++) step(0, 4'h0, 8'h00, 1, "R6");

    // unused slots leave an unsaturated count alone
    step(1, 4'hD, 8'h00, 0, "R5");
    step(1, 4'hE, 8'hFE, 0, "R6");
    step(1, 4'hF, 8'hFF, 0, "R7");
    for (int i = 0; i < 13; i++) step(1, 4'(i), 8'hC3, 0, "R9");
    step(0, 4'h0, 8'h00, 1, "R9");

    // full run from zero while disarmed, then arm on the held value
    step(1, 4'hD, 8'h00, 0, "R5");
    for (int i = 0; i < 65535; i++) step(0, 4'h0, 8'h00, 1, "R4");
    for (int i = 0; i < 10; i++) step(0, 4'h0, 8'h00, 1, "R3");
    step(1, 4'hF, 8'hFF, 0, "R3");
    step(1, 4'hD, 8'h00, 0, "R5");
    step(0, 4'h0, 8'h00, 0, "R5");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    report();
  end
endmodule